// File: doc/BRIEF.md
# SMBus Indexed Register Slave

This block is the serial front end of a small configuration register file, about eighteen bytes. It watches an SMBus/I2C clock and data pair that are oversampled by the system clock. It finds start, repeated start and stop conditions, checks a 7-bit device address and decodes a command byte. It acknowledges by pulling the data line low through an output enable. Incoming data bytes leave the block as a one-cycle write strobe that carries a register index and a data byte. Outgoing bytes are fetched combinationally through a read index and read data port.

Bit 7 of the command byte picks the addressing mode. When it is set, bits 6:0 give the register offset for byte and word transfers. When it is clear, the transfer is a block transfer starting at register 0. A block write carries a byte count before its data. A block read answers with a byte count before its data. The register pointer advances after every data byte. Two register indices are read-only and never receive a write strobe.

The controller runs through eight named states:
- `ST_IDLE` waits, ignoring the bus.
- `ST_ADDR` receives the address byte.
- `ST_CMD` receives the command byte.
- `ST_COUNT` receives the block-write count.
- `ST_WDATA` receives data bytes.
- `ST_ACK` drives the acknowledge bit.
- `ST_SEND` shifts a byte out.
- `ST_MACK` samples the master's acknowledge.

The transitions are:
- A start condition moves any state to `ST_ADDR`. A stop condition moves any state to `ST_IDLE`.
- `ST_ADDR`, `ST_CMD`, `ST_COUNT` and `ST_WDATA` move to `ST_ACK` when a byte completes and is accepted. A refused byte moves them to `ST_IDLE`.
- `ST_ACK` leaves on the falling SCL edge for the follow-up state recorded when the byte was accepted. That state is `ST_CMD` after a write address, `ST_SEND` after a read address, `ST_COUNT` or `ST_WDATA` after a command, and `ST_WDATA` after a count or data byte.
- `ST_SEND` moves to `ST_MACK` after the eighth bit.
- `ST_MACK` returns to `ST_SEND` when the master acknowledges, and to `ST_IDLE` on a not-acknowledge.

Top module: `smbslv_top`

## Requirements
- R1: A start or repeated start seen in any state begins address reception. A stop seen in any state returns the slave to idle with the data line released.
- R2: The slave acknowledges only an address byte whose upper seven bits equal DEV_ADDR (default 7'h69). After any other address it drives nothing and issues no write strobe until the next start.
- R3: A command byte with bit 7 set loads the register pointer from bits 6:0. Each received data byte then produces one single-cycle write strobe at the pointer, and the pointer increments after every data byte.
- R4: A command byte with bit 7 clear and any of bits 6:0 set is not acknowledged, and the data that follows is ignored.
- R5: In a block write (command 8'h00), the byte after the command is a count that is acknowledged but never written. The data bytes are then written to index 0, 1, 2 and so on. A stop after any complete byte ends the write with only the completed bytes stored.
- R6: In a block read (command 8'h00, repeated start, read address), the first byte returned is the register count NREGS (default 18). Registers 0, 1, ... follow in ascending order.
- R7: In an indexed read, the bytes returned start at the command offset: the low byte (offset) first, then the high byte (offset+1). A master not-acknowledge ends the read and the slave releases the data line.
- R8: Bytes are shifted most-significant bit first in both directions.
- R9: Indices 8 and 15 (RO_MASK) and any index at or above NREGS produce no write strobe. A read of an index at or above NREGS returns 8'h00 whatever the read port supplies.
- R10: A read address that is not preceded by an accepted command within the same transfer is not acknowledged.
- R11: The data-line output enable changes only while SCL is low.
- R12: During and right after reset the data line is released and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_idx | output | 7 | Register index of the write |
| wr_data | output | 8 | Byte to write |
| rd_idx | output | 7 | Register index whose value the next outgoing byte takes |
| rd_data | input | 8 | Register value at rd_idx, combinational |

## Verification
The checks assume that SCL and SDA are each held stable for several system clocks. They also assume that SDA changes only while SCL is low, except when the master forms a start or a stop. Under these conditions the synchronized edge events are clean, and the output-enable timing check only ever sees SCL low. The bench master drives every line with a half-period of ten system clocks. It moves SDA two clocks after lowering SCL, so every edge falls inside these assumptions.

// File: rtl/smbslv_pkg.sv
package smbslv_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_COUNT,
        ST_WDATA,
        ST_ACK,
        ST_SEND,
        ST_MACK
    } smb_state_t;
endpackage

// File: rtl/smbslv_line_mon.sv
module smbslv_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sync;
    logic [TOP:0] sda_sync;
    logic         scl_prev;
    logic         sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[TOP-1:0], scl_in};
            sda_sync <= {sda_sync[TOP-1:0], sda_in};
            scl_prev <= scl_sync[TOP];
            sda_prev <= sda_sync[TOP];
        end
    end

    assign scl_q     = scl_sync[TOP];
    assign sda_q     = sda_sync[TOP];
    assign scl_rise  = scl_q & ~scl_prev;
    assign scl_fall  = ~scl_q & scl_prev;
    assign start_det = scl_q & scl_prev & sda_prev & ~sda_q;
    assign stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;
endmodule

// File: rtl/smbslv_rx_shift.sv
module smbslv_rx_shift #(
    parameter int W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   sample,
    input  logic                   bit_in,
    output logic [W-1:0]           data,
    output logic [$clog2(W+1)-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (sample) begin
            data  <= {data[W-2:0], bit_in};
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/smbslv_tx_shift.sv
module smbslv_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sreg <= '0;
        else if (load)  sreg <= load_val;
        else if (shift) sreg <= {sreg[W-2:0], 1'b0};
    end

    assign msb = sreg[W-1];
endmodule

// File: rtl/smbslv_top.sv
module smbslv_top
    import smbslv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NREGS       = 18,
    parameter logic [NREGS-1:0] RO_MASK = 18'h08100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [6:0] wr_idx,
    output logic [7:0] wr_data,
    output logic [6:0] rd_idx,
    input  logic [7:0] rd_data
);
    localparam int           IDXW       = 7;
    localparam logic [IDXW:0] NREGS_W   = (IDXW+1)'(NREGS);
    localparam logic [7:0]   COUNT_BYTE = 8'(NREGS);
    localparam logic [127:0] RO_WIDE    = 128'(RO_MASK);

    logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;

    smbslv_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_state_t state, state_n, ack_next;
    logic [IDXW-1:0] ptr;
    logic            has_cmd;
    logic            cnt_pending;
    logic            mack_nack;
    logic [2:0]      tx_bits;

    logic [7:0] rx_data;
    logic [3:0] rx_cnt;
    logic       rx_st, byte_end, rx_clear;
    logic       addr_hit, cmd_ok, ptr_valid, writable, load_tx, tx_msb;
    logic [7:0] tx_val;

    assign rx_st    = (state == ST_ADDR) || (state == ST_CMD) ||
                      (state == ST_COUNT) || (state == ST_WDATA);
    assign byte_end = rx_st && scl_fall && (rx_cnt == 4'd8);
    assign rx_clear = start_det || byte_end;

    smbslv_rx_shift #(.W(8)) u_rx (
        .clk(clk), .rst_n(rst_n), .clear(rx_clear),
        .sample(rx_st && scl_rise), .bit_in(sda_q),
        .data(rx_data), .count(rx_cnt)
    );

    assign addr_hit  = (rx_data[7:1] == DEV_ADDR) && (!rx_data[0] || has_cmd);
    assign cmd_ok    = rx_data[7] || (rx_data[6:0] == 7'd0);
    assign ptr_valid = {1'b0, ptr} < NREGS_W;
    assign writable  = ptr_valid && !RO_WIDE[ptr];
    assign load_tx   = scl_fall &&
                       (((state == ST_ACK) && (ack_next == ST_SEND)) ||
                        ((state == ST_MACK) && !mack_nack));
    assign tx_val    = cnt_pending ? COUNT_BYTE : (ptr_valid ? rd_data : 8'h00);

    smbslv_tx_shift #(.W(8)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(load_tx), .load_val(tx_val),
        .shift((state == ST_SEND) && scl_fall), .msb(tx_msb)
    );

    // next-state decode
    always_comb begin
        state_n = state;
        if (stop_det) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:  state_n = ST_IDLE;
                ST_ADDR:  if (byte_end) state_n = addr_hit ? ST_ACK : ST_IDLE;
                ST_CMD:   if (byte_end) state_n = cmd_ok ? ST_ACK : ST_IDLE;
                ST_COUNT: if (byte_end) state_n = ST_ACK;
                ST_WDATA: if (byte_end) state_n = ST_ACK;
                ST_ACK:   if (scl_fall) state_n = ack_next;
                ST_SEND:  if (scl_fall && tx_bits == 3'd7) state_n = ST_MACK;
                ST_MACK:  if (scl_fall) state_n = mack_nack ? ST_IDLE : ST_SEND;
                default:  state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // transfer context: pointer, mode flags, follow-up state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr         <= '0;
            has_cmd     <= 1'b0;
            cnt_pending <= 1'b0;
            mack_nack   <= 1'b0;
            tx_bits     <= '0;
            ack_next    <= ST_IDLE;
        end else if (stop_det) begin
            has_cmd     <= 1'b0;
            cnt_pending <= 1'b0;
        end else begin
            if (byte_end) begin
                unique case (state)
                    ST_ADDR:  ack_next <= rx_data[0] ? ST_SEND : ST_CMD;
                    ST_CMD: begin
                        if (cmd_ok) begin
                            has_cmd     <= 1'b1;
                            cnt_pending <= ~rx_data[7];
                            ptr         <= rx_data[7] ? rx_data[6:0] : '0;
                            ack_next    <= rx_data[7] ? ST_WDATA : ST_COUNT;
                        end
                    end
                    ST_COUNT: begin
                        cnt_pending <= 1'b0;
                        ack_next    <= ST_WDATA;
                    end
                    ST_WDATA: begin
                        ptr      <= ptr + 1'b1;
                        ack_next <= ST_WDATA;
                    end
                    default: ack_next <= ST_IDLE;
                endcase
            end
            if (load_tx) begin
                tx_bits <= '0;
                if (cnt_pending) cnt_pending <= 1'b0;
                else             ptr <= ptr + 1'b1;
            end else if ((state == ST_SEND) && scl_fall) begin
                tx_bits <= tx_bits + 1'b1;
            end
            if ((state == ST_MACK) && scl_rise) mack_nack <= sda_q;
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_ACK:  sda_oe = 1'b1;
            ST_SEND: sda_oe = ~tx_msb;
            default: sda_oe = 1'b0;
        endcase
        wr_en   = (state == ST_WDATA) && byte_end && writable;
        wr_idx  = ptr;
        wr_data = rx_data;
        rd_idx  = ptr;
    end
endmodule

// File: rtl/smbslv_checker.sv
module smbslv_checker
    import smbslv_pkg::*;
#(
    parameter int NREGS = 18,
    parameter logic [NREGS-1:0] RO_MASK = 18'h08100
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_q,
    input logic       start_det,
    input logic       stop_det,
    input smb_state_t state,
    input logic       sda_oe,
    input logic       wr_en,
    input logic [6:0] wr_idx
);
    localparam logic [7:0]   LIM   = 8'(NREGS);
    localparam logic [127:0] RO_W  = 128'(RO_MASK);

    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    assert_start_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_ADDR));

    assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    assert_wr_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (({1'b0, wr_idx} < LIM) && !RO_W[wr_idx]));

    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_q);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!sda_oe && !wr_en));
endmodule

bind smbslv_top smbslv_checker #(.NREGS(NREGS), .RO_MASK(RO_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .start_det(start_det),
    .stop_det(stop_det), .state(state), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_idx(wr_idx)
);

// File: tb/smbslv_top_test.sv
module smbslv_top_test;
    localparam int H = 10;
    localparam logic [6:0] DEV = 7'h69;
    localparam int NR = 18;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe, wr_en;
    logic [6:0] wr_idx, rd_idx;
    logic [7:0] wr_data, rd_data;
    wire sda_bus = m_sda & ~sda_oe;

    smbslv_top uut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    // register file behind the slave
    logic [7:0] regs [NR];
    int wr_cnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) regs[i] <= 8'h10 + 8'(i);
        end else if (wr_en) begin
            if (wr_idx < NR) regs[wr_idx] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end
    assign rd_data = (rd_idx < NR) ? regs[rd_idx] : 8'hEE;

    // R11 monitor: enable may only move while SCL is low
    int oe_viol = 0;
    logic prev_oe = 1'b0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (sda_oe !== prev_oe && m_scl) oe_viol <= oe_viol + 1;
            prev_oe <= sda_oe;
        end
    end

    int total = 0;
    int bad = 0;

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_start;
        m_sda = 1; m_scl = 1; hold(H);
        m_sda = 0; hold(H);
        m_scl = 0; hold(2);
    endtask

    task automatic do_rstart;
        m_sda = 1; hold(H);
        m_scl = 1; hold(H);
        m_sda = 0; hold(H);
        m_scl = 0; hold(2);
    endtask

    task automatic do_stop;
        m_sda = 0; hold(H);
        m_scl = 1; hold(H);
        m_sda = 1; hold(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hold(H);
            m_scl = 1; hold(H);
            m_scl = 0; hold(2);
        end
        m_sda = 1; hold(H);
        m_scl = 1; hold(H / 2);
        ack = !sda_bus;
        hold(H / 2);
        m_scl = 0; hold(2);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        m_sda = 1;
        for (int i = 7; i >= 0; i--) begin
            hold(H);
            m_scl = 1; hold(H / 2);
            b[i] = sda_bus;
            hold(H / 2);
            m_scl = 0; hold(2);
        end
        m_sda = nack; hold(H);
        m_scl = 1; hold(H);
        m_scl = 0; hold(2);
        m_sda = 1;
    endtask

    task automatic byte_write(input logic [6:0] off, input logic [7:0] d);
        logic a;
        do_start;
        send_byte({DEV, 1'b0}, a);
        send_byte({1'b1, off}, a);
        send_byte(d, a);
        do_stop;
    endtask

    task automatic byte_read(input logic [6:0] off, output logic [7:0] d);
        logic a;
        do_start;
        send_byte({DEV, 1'b0}, a);
        send_byte({1'b1, off}, a);
        do_rstart;
        send_byte({DEV, 1'b1}, a);
        recv_byte(1'b1, d);
        do_stop;
    endtask

    // {offset, data written, value expected on read back}
    localparam logic [23:0] VECS [6] = '{
        24'h03_5A_5A,
        24'h05_81_81,
        24'h08_55_18,
        24'h0F_33_1F,
        24'h14_77_00,
        24'h11_C3_C3
    };

    initial begin
        logic a;
        logic [7:0] d;
        int snap;

        hold(5);
        chk("R12 reset sda_oe", {7'd0, sda_oe}, 8'd0);
        chk("R12 reset wr_en", {7'd0, wr_en}, 8'd0);
        rst_n = 1;
        hold(5);
        chk("R12 after reset sda_oe", {7'd0, sda_oe}, 8'd0);

        // table walk: byte write then byte read back
        for (int v = 0; v < 6; v++) begin
            byte_write(VECS[v][22:16], VECS[v][15:8]);
            byte_read(VECS[v][22:16], d);
            chk("R3/R8/R9 byte write+read", d, VECS[v][7:0]);
        end

        // R7 word write and word read, low byte first
        do_start;
        send_byte({DEV, 1'b0}, a);
        chk("R2 address ack", {7'd0, a}, 8'd1);
        send_byte(8'h83, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        do_stop;
        do_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h83, a);
        do_rstart;
        send_byte({DEV, 1'b1}, a);
        recv_byte(1'b0, d);
        chk("R7 word low byte", d, 8'h11);
        recv_byte(1'b1, d);
        chk("R7 word high byte R3", d, 8'h22);
        do_stop;
        chk("R7 released after nack", {7'd0, sda_oe}, 8'd0);

        // R5 block write, R6 block read
        do_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h00, a);
        chk("R5 block command ack", {7'd0, a}, 8'd1);
        send_byte(8'h03, a);
        send_byte(8'hA0, a);
        send_byte(8'hA1, a);
        send_byte(8'hA2, a);
        do_stop;
        do_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h00, a);
        do_rstart;
        send_byte({DEV, 1'b1}, a);
        recv_byte(1'b0, d);
        chk("R6 block count", d, 8'(NR));
        recv_byte(1'b0, d);
        chk("R5/R6 block byte 0", d, 8'hA0);
        recv_byte(1'b0, d);
        chk("R5/R6 block byte 1", d, 8'hA1);
        recv_byte(1'b1, d);
        chk("R5/R6 block byte 2", d, 8'hA2);
        do_stop;

        // R5 stop after one data byte
        snap = wr_cnt;
        do_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h00, a);
        send_byte(8'h05, a);
        send_byte(8'h3C, a);
        do_stop;
        chk("R5 partial block strobes", 8'(wr_cnt - snap), 8'd1);
        byte_read(7'd0, d);
        chk("R5 partial block byte 0", d, 8'h3C);
        byte_read(7'd1, d);
        chk("R5 partial block byte 1 kept", d, 8'hA1);

        // R2 foreign address, then R1 repeated start recovers
        snap = wr_cnt;
        do_start;
        send_byte({7'h22, 1'b0}, a);
        chk("R2 foreign address nack", {7'd0, a}, 8'd0);
        send_byte(8'h82, a);
        send_byte(8'h99, a);
        do_rstart;
        send_byte({DEV, 1'b0}, a);
        chk("R1 repeated start accepted", {7'd0, a}, 8'd1);
        do_stop;
        chk("R2 no strobe for foreign address", 8'(wr_cnt - snap), 8'd0);

        // R4 malformed block command
        snap = wr_cnt;
        do_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h05, a);
        chk("R4 bad command nack", {7'd0, a}, 8'd0);
        send_byte(8'h44, a);
        do_stop;
        chk("R4 no strobe after bad command", 8'(wr_cnt - snap), 8'd0);

        // R10 read with no command
        do_start;
        send_byte({DEV, 1'b1}, a);
        chk("R10 read without command nack", {7'd0, a}, 8'd0);
        do_stop;
        chk("R1 idle after stop", {7'd0, sda_oe}, 8'd0);

        chk("R11 enable moved with SCL high", 8'(oe_viol), 8'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule